// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master controlled through six 32-bit registers. Software programs a mode word and then writes data words to a transmit register. Each write sends one word over `sck_o`, `mosi_o` and `miso_i`. When a word completes, the bits shifted in land in a receive register and an event flag is raised. Event flags can be masked into a single level interrupt.

The mode word selects the following:
- word length: 4 to 16 bits, or 32;
- SCK idle level and sampling phase;
- bit order;
- an internal loopback from MOSI back to the receive shifter;
- the SCK rate, from a prescale modulus and an optional extra divide by 16;
- an alignment mode that moves narrow words toward the upper end of the data registers.

Mode fields are only taken while the block is disabled, so software reconfigures it by writing once with enable clear and once with enable set.

Top module: `spi_host_ctrl`

## Requirements
- R1: Registers sit at byte addresses 0x20 mode, 0x24 event, 0x28 mask, 0x2C command, 0x30 transmit, 0x34 receive. After reset, mode reads 0x2E7F0000, event reads 0x00000100, mask reads 0 and `sck_o` is high.
- R2: Mode bits 23:20 hold a length code c. A code of 1..15 gives a word of c+1 bits, and 0 gives 32 bits. A word lasts 2×bits SCK half-periods.
- R3: One SCK half-period lasts 2×(PM+1) clocks when mode bit 27 is clear and 32×(PM+1) clocks when it is set, with PM in mode bits 19:16. While no word is in progress, SCK rests at mode bit 29.
- R4: With mode bit 28 clear, each bit is driven before its leading SCK edge and sampled on that edge. With it set, each bit is driven at the leading edge and sampled on the trailing edge.
- R5: Mode bit 26 set sends and receives MSB first. When it is clear, LSB goes first. The receive register holds the word right-aligned in both cases.
- R6: With mode bit 30 set, the receive shifter takes MOSI and `miso_i` is ignored.
- R7: A transmit write clears event bit 8. The word starts in the same cycle when mode bits 24 (enable) and 25 (master) are set. At its end, the receive register is loaded, event bit 9 is set and event bit 8 is set again.
- R8: Writing a 1 to an event bit clears that bit, and a 0 leaves it unchanged. Reading the receive register leaves event bit 9 set.
- R9: `irq_o` is high exactly when some event bit among 9 and 8 is set together with the same mask bit.
- R10: With mode bit 14 set and MSB first, an 8-bit or shorter word is taken from transmit bits 31:24 and returned at receive bit 16. A 9..16-bit word uses bit 16 upward in both directions. With LSB first, transmit data is right-aligned, and an 8-bit or shorter received word starts at bit 8.
- R11: Clearing enable during a word aborts it. From the second clock edge after the write, SCK is at its idle level. Event bit 9 and the receive register are unchanged, and event bit 8 is set.
- R12: While enable is set, a mode write changes only bit 24, and every other mode field keeps its value.
- R13: A transmit write while the block is disabled is held, generates no SCK edges, and starts one cycle after enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 6 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Masked event interrupt |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench tries the transfer path with the following mode patterns:
- all four idle-level and phase combinations;
- both bit orders;
- lengths of 4, 8, 16 and 32 bits;
- both prescaler ranges.

A slave model answers with a word unrelated to the transmitted one, and SCK and MOSI are compared on every clock against the timing the requirements predict. A shifted edge, a swapped bit order or an off-by-one length therefore each show up in a different place: on SCK, on MOSI, or in the received word. Loopback runs use a slave word that is the inverse of the data sent, so any leak of `miso_i` into the receive path changes the result. Alignment, abort, held-start and event-clearing runs check register contents against values computed from the field rules.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned LEN_W = 4;
  localparam int unsigned PM_W  = 4;
  localparam int unsigned NB_W  = $clog2(DW) + 1;

  localparam int unsigned M_LOOP   = 30;
  localparam int unsigned M_CPOL   = 29;
  localparam int unsigned M_CPHA   = 28;
  localparam int unsigned M_DIV16  = 27;
  localparam int unsigned M_MSB    = 26;
  localparam int unsigned M_MASTER = 25;
  localparam int unsigned M_EN     = 24;
  localparam int unsigned M_LEN_LO = 20;
  localparam int unsigned M_PM_LO  = 16;
  localparam int unsigned M_ALT    = 14;

  localparam int unsigned E_RNE = 9;
  localparam int unsigned E_TNF = 8;

  localparam logic [DW-1:0] MODE_RST  = 32'h2E7F_0000;
  localparam logic [DW-1:0] MODE_IMPL = 32'h7FFF_4000;

  typedef struct packed {
    logic             loop;
    logic             cpol;
    logic             cpha;
    logic             div16;
    logic             msb;
    logic             master;
    logic             en;
    logic [LEN_W-1:0] len;
    logic [PM_W-1:0]  pm;
    logic             alt;
  } mode_t;

  function automatic mode_t decode_mode(logic [DW-1:0] r);
    mode_t m;
    m.loop   = r[M_LOOP];
    m.cpol   = r[M_CPOL];
    m.cpha   = r[M_CPHA];
    m.div16  = r[M_DIV16];
    m.msb    = r[M_MSB];
    m.master = r[M_MASTER];
    m.en     = r[M_EN];
    m.len    = r[M_LEN_LO +: LEN_W];
    m.pm     = r[M_PM_LO +: PM_W];
    m.alt    = r[M_ALT];
    return m;
  endfunction

  function automatic logic [NB_W-1:0] word_bits(logic [LEN_W-1:0] c);
    return (c == '0) ? NB_W'(DW) : NB_W'(c) + NB_W'(1);
  endfunction

  function automatic logic [4:0] tx_shift(mode_t m, logic [NB_W-1:0] n);
    if (!m.alt || !m.msb || n > NB_W'(16)) return 5'd0;
    return (n <= NB_W'(8)) ? 5'd24 : 5'd16;
  endfunction

  function automatic logic [4:0] rx_shift(mode_t m, logic [NB_W-1:0] n);
    if (!m.alt || n > NB_W'(16)) return 5'd0;
    if (m.msb) return 5'd16;
    return (n <= NB_W'(8)) ? 5'd8 : 5'd0;
  endfunction
endpackage

// File: rtl/spi_host_prescaler.sv
module spi_host_prescaler #(
  parameter int unsigned PM_W    = 4,
  parameter int unsigned LO_HALF = 2,
  parameter int unsigned HI_HALF = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            div_hi_i,
  input  logic [PM_W-1:0] pm_i,
  output logic            tick_o
);
  localparam int unsigned MAX_HALF = HI_HALF * (2 ** PM_W);
  localparam int unsigned CW       = $clog2(MAX_HALF) + 1;

  logic [CW-1:0] cnt_q, half_len;

  assign half_len = (div_hi_i ? CW'(HI_HALF) : CW'(LO_HALF)) * (CW'(pm_i) + CW'(1));
  assign tick_o   = run_i && (cnt_q == half_len - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || tick_o)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + CW'(1);
  end

  // half-period is at least two clocks
  assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
  parameter int unsigned DW = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     abort_i,
  input  logic                     tick_i,
  input  logic                     cpol_i,
  input  logic                     cpha_i,
  input  logic                     msb_i,
  input  logic [$clog2(DW):0]      nbits_i,
  input  logic [DW-1:0]            tx_word_i,
  input  logic                     sdi_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     sck_o,
  output logic                     sdo_o,
  output logic [DW-1:0]            rx_word_o
);
  localparam int unsigned BW = $clog2(DW);
  localparam int unsigned NW = BW + 1;
  localparam int unsigned EW = NW + 1;

  logic          busy_q, sck_q;
  logic [EW-1:0] e_q, idx, sel_full;
  logic [DW-1:0] tx_q, rx_q, rx_next;
  logic [BW-1:0] bit_sel, idx_sel;
  logic          last_edge, sample;

  always_comb begin
    if (cpha_i) idx = (e_q == '0) ? '0 : ((e_q - EW'(1)) >> 1);
    else        idx = e_q >> 1;
    sel_full = msb_i ? (EW'(nbits_i) - EW'(1) - idx) : idx;
  end
  assign bit_sel   = sel_full[BW-1:0];
  assign idx_sel   = idx[BW-1:0];
  assign last_edge = (e_q == {nbits_i, 1'b0} - EW'(1));
  assign sample    = busy_q && tick_i && (e_q[0] == cpha_i);

  always_comb begin
    rx_next = rx_q;
    if (sample) begin
      if (msb_i) rx_next = {rx_q[DW-2:0], sdi_i};
      else       rx_next[idx_sel] = sdi_i;
    end
  end

  assign done_o    = busy_q && tick_i && last_edge && !abort_i;
  assign rx_word_o = rx_next;
  assign busy_o    = busy_q;
  assign sck_o     = sck_q;
  assign sdo_o     = busy_q & tx_q[bit_sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      e_q    <= '0;
      sck_q  <= 1'b1;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      e_q    <= '0;
      sck_q  <= cpol_i;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      e_q    <= '0;
      sck_q  <= cpol_i;
      tx_q   <= tx_word_i;
      rx_q   <= '0;
    end else if (busy_q && tick_i) begin
      rx_q <= rx_next;
      if (last_edge) begin
        busy_q <= 1'b0;
        e_q    <= '0;
        sck_q  <= cpol_i;
      end else begin
        e_q   <= e_q + EW'(1);
        sck_q <= ~sck_q;
      end
    end else if (!busy_q) begin
      sck_q <= cpol_i;
    end
  end

  assert_edge_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (e_q < {nbits_i, 1'b0}));
  assert_idle_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> (sck_o == $past(cpol_i)));
  assert_abort_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && sck_o == $past(cpol_i)));
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int unsigned AW     = 6,
  parameter int unsigned BASE   = 32,
  parameter int unsigned DIV_LO = 4,
  parameter int unsigned DIV_HI = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  output logic          irq_o,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i
);
  localparam logic [AW-1:0] A_MODE = AW'(BASE);
  localparam logic [AW-1:0] A_EV   = AW'(BASE + 4);
  localparam logic [AW-1:0] A_MASK = AW'(BASE + 8);
  localparam logic [AW-1:0] A_CMD  = AW'(BASE + 12);
  localparam logic [AW-1:0] A_TX   = AW'(BASE + 16);
  localparam logic [AW-1:0] A_RX   = AW'(BASE + 20);
  localparam logic [DW-1:0] EV_BITS  = (DW'(1) << E_RNE) | (DW'(1) << E_TNF);
  localparam logic [DW-1:0] NOT_EN   = ~(DW'(1) << M_EN);

  logic [DW-1:0] mode_q, mask_q, cmd_q, txd_q, rxd_q, ev_vec;
  logic          rne_q, tnf_q, pend_q;
  logic          wr, tx_wr, ev_wr, run, start, busy, done, tick, abort_hit, sdi;
  logic [DW-1:0] tx_src, tx_word, rx_word;
  logic [NB_W-1:0] nbits;
  mode_t m;

  assign m      = decode_mode(mode_q);
  assign nbits  = word_bits(m.len);
  assign wr     = bus_req_i && bus_we_i;
  assign tx_wr  = wr && (bus_addr_i == A_TX);
  assign ev_wr  = wr && (bus_addr_i == A_EV);
  assign run    = m.en && m.master;
  assign start  = (tx_wr || pend_q) && run && !busy;
  assign tx_src = tx_wr ? bus_wdata_i : txd_q;
  assign tx_word = tx_src >> tx_shift(m, nbits);
  assign abort_hit = busy && !m.en;
  assign sdi    = m.loop ? mosi_o : miso_i;

  spi_host_prescaler #(
    .PM_W(PM_W), .LO_HALF(DIV_LO / 2), .HI_HALF(DIV_HI / 2)
  ) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy),
    .div_hi_i(m.div16), .pm_i(m.pm), .tick_o(tick)
  );

  spi_host_shifter #(.DW(DW)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .abort_i(!m.en),
    .tick_i(tick), .cpol_i(m.cpol), .cpha_i(m.cpha), .msb_i(m.msb),
    .nbits_i(nbits), .tx_word_i(tx_word), .sdi_i(sdi),
    .busy_o(busy), .done_o(done), .sck_o(sck_o), .sdo_o(mosi_o),
    .rx_word_o(rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      mask_q <= '0;
      cmd_q  <= '0;
      txd_q  <= '0;
      rxd_q  <= '0;
      pend_q <= 1'b0;
      rne_q  <= 1'b0;
      tnf_q  <= 1'b1;
    end else begin
      if (wr && bus_addr_i == A_MODE) begin
        if (m.en) mode_q[M_EN] <= bus_wdata_i[M_EN];
        else      mode_q       <= bus_wdata_i & MODE_IMPL;
      end
      if (wr && bus_addr_i == A_MASK) mask_q <= bus_wdata_i & EV_BITS;
      if (wr && bus_addr_i == A_CMD)  cmd_q  <= bus_wdata_i;
      if (tx_wr) txd_q <= bus_wdata_i;

      if (start)      pend_q <= 1'b0;
      else if (tx_wr) pend_q <= 1'b1;

      if (done) rxd_q <= rx_word << rx_shift(m, nbits);

      if (done)                        rne_q <= 1'b1;
      else if (ev_wr && bus_wdata_i[E_RNE]) rne_q <= 1'b0;

      if ((done || abort_hit) && !pend_q && !tx_wr) tnf_q <= 1'b1;
      else if (tx_wr || (ev_wr && bus_wdata_i[E_TNF])) tnf_q <= 1'b0;
    end
  end

  always_comb begin
    ev_vec        = '0;
    ev_vec[E_RNE] = rne_q;
    ev_vec[E_TNF] = tnf_q;
  end

  assign irq_o = |(ev_vec & mask_q);

  always_comb begin
    case (bus_addr_i)
      A_MODE:  bus_rdata_o = mode_q;
      A_EV:    bus_rdata_o = ev_vec;
      A_MASK:  bus_rdata_o = mask_q;
      A_CMD:   bus_rdata_o = cmd_q;
      A_TX:    bus_rdata_o = txd_q;
      A_RX:    bus_rdata_o = rxd_q;
      default: bus_rdata_o = '0;
    endcase
  end

  assert_busy_not_tnf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !tnf_q);
  assert_done_sets_rne_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> rne_q);
  assert_fields_locked_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && bus_addr_i == A_MODE && m.en) |=> ((mode_q & NOT_EN) == $past(mode_q & NOT_EN)));
  assert_disabled_idle_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m.en |=> !busy);
endmodule

// File: tb/spi_host_ctrl_tb.sv
module spi_host_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, miso = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sck, mosi;

  always #2 clk = ~clk;

  spi_host_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .sck_o(sck), .mosi_o(mosi), .miso_i(miso)
  );

  localparam logic [5:0] A_MODE = 6'h20, A_EV = 6'h24, A_MASK = 6'h28,
                         A_CMD = 6'h2C, A_TX = 6'h30, A_RX = 6'h34;
  localparam logic [31:0] EN = 32'h0100_0000;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  bit m_act = 0;
  int m_j, m_h, m_n;
  bit g_cpol, g_cpha, g_msb;
  logic [31:0] m_tx, m_slv, g_cfg;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_act) begin
      if (m_j < 0) chk("R13 sck held", {31'b0, sck}, {31'b0, g_cpol});
      else if (m_j >= 2 * m_n * m_h) begin
        chk("R3 sck idle after word", {31'b0, sck}, {31'b0, g_cpol});
        m_act = 0;
      end else begin
        int e, idx, b;
        e = m_j / m_h;
        chk("R3 R4 sck level", {31'b0, sck}, {31'b0, g_cpol ^ e[0]});
        idx = g_cpha ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
        b = g_msb ? (m_n - 1 - idx) : idx;
        chk("R4 R5 mosi bit", {31'b0, mosi}, {31'b0, m_tx[b]});
        miso = m_slv[b];
      end
      m_j++;
    end
  end

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  function automatic logic [31:0] mk(bit loop, bit cpol, bit cpha, bit d16, bit msb,
                                     int len, int pm, bit alt);
    return (32'(loop) << 30) | (32'(cpol) << 29) | (32'(cpha) << 28) | (32'(d16) << 27) |
           (32'(msb) << 26) | (32'h1 << 25) | (32'(len) << 20) | (32'(pm) << 16) |
           (32'(alt) << 14);
  endfunction

  task automatic set_cfg(bit loop, bit cpol, bit cpha, bit d16, bit msb, int len, int pm, bit alt);
    g_cfg = mk(loop, cpol, cpha, d16, msb, len, pm, alt);
    g_cpol = cpol; g_cpha = cpha; g_msb = msb;
    m_n = (len == 0) ? 32 : len + 1;
    m_h = (d16 ? 32 : 2) * (pm + 1);
    bus_wr(A_MODE, g_cfg & ~EN);
    bus_wr(A_MODE, g_cfg | EN);
  endtask

  task automatic xfer(input logic [31:0] wd, input logic [31:0] tx_eff, input logic [31:0] slv,
                      input logic [31:0] exp_rx, input string rq, input bit keep);
    logic [31:0] r;
    m_tx = tx_eff; m_slv = slv;
    bus_wr(A_TX, wd);
    m_j = 0; m_act = 1;
    wait (m_act == 0);
    bus_rd(A_RX, r);
    chk(rq, r, exp_rx);
    bus_rd(A_EV, r);
    chk("R7 events after word", r, 32'h300);
    if (!keep) bus_wr(A_EV, 32'h200);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    bus_rd(A_MODE, r); chk("R1 mode reset", r, 32'h2E7F_0000);
    bus_rd(A_EV, r);   chk("R1 event reset", r, 32'h100);
    bus_rd(A_MASK, r); chk("R1 mask reset", r, 32'h0);
    chk("R1 sck reset", {31'b0, sck}, 32'h1);
    bus_wr(A_CMD, 32'h1357_9BDF);
    bus_rd(A_CMD, r);  chk("R1 command register", r, 32'h1357_9BDF);

    // R2 R4 R5 R7: 8-bit, idle low, sample leading, MSB first
    set_cfg(0, 0, 0, 0, 1, 7, 0, 0);
    xfer(32'hA5, 32'hA5, 32'h3C, 32'h3C, "R7 R2 rx 8-bit mode0", 0);
    // 4-bit, idle high, sample trailing, LSB first, PM=1
    set_cfg(0, 1, 1, 0, 0, 3, 1, 0);
    xfer(32'h9, 32'h9, 32'h6, 32'h6, "R2 R4 R5 rx 4-bit lsb", 0);
    // 16-bit, idle low, trailing, MSB, PM=2
    set_cfg(0, 0, 1, 0, 1, 15, 2, 0);
    xfer(32'hBEEF, 32'hBEEF, 32'h1234, 32'h1234, "R2 rx 16-bit", 0);
    // 32-bit code 0, idle high, leading
    set_cfg(0, 1, 0, 0, 1, 0, 0, 0);
    xfer(32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'h1234_5678, 32'h1234_5678, "R2 rx 32-bit", 0);
    // 32-bit LSB first
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
    xfer(32'h8000_0001, 32'h8000_0001, 32'h0F0F_00F1, 32'h0F0F_00F1, "R5 rx 32-bit lsb", 0);
    // R3 divide-by-16 range, PM=1
    set_cfg(0, 0, 0, 1, 1, 3, 1, 0);
    xfer(32'hA, 32'hA, 32'h5, 32'h5, "R3 rx slow clock", 0);

    // R6 loopback: slave sends the inverse
    set_cfg(1, 0, 1, 0, 1, 7, 0, 0);
    xfer(32'h5B, 32'h5B, 32'hA4, 32'h5B, "R6 loopback ignores miso", 0);

    // R8 R9 event clearing and interrupt
    set_cfg(0, 0, 0, 0, 1, 7, 0, 0);
    xfer(32'h11, 32'h11, 32'hC7, 32'hC7, "R7 rx before clear", 1);
    bus_rd(A_RX, r); bus_rd(A_RX, r);
    bus_rd(A_EV, r); chk("R8 rx read keeps rne", r, 32'h300);
    chk("R9 irq off with mask 0", {31'b0, irq}, 32'h0);
    bus_wr(A_MASK, 32'h200);
    #1 chk("R9 irq on rne", {31'b0, irq}, 32'h1);
    bus_wr(A_EV, 32'h100);
    bus_rd(A_EV, r); chk("R8 w1c tnf only", r, 32'h200);
    bus_wr(A_EV, 32'h0);
    bus_rd(A_EV, r); chk("R8 zero write no effect", r, 32'h200);
    bus_wr(A_EV, 32'hFFFF_FFFF);
    bus_rd(A_EV, r); chk("R8 w1c all", r, 32'h0);
    #1 chk("R9 irq off after clear", {31'b0, irq}, 32'h0);
    bus_wr(A_MASK, 32'h100);
    xfer(32'h22, 32'h22, 32'h81, 32'h81, "R7 rx", 0);
    #1 chk("R9 irq on tnf", {31'b0, irq}, 32'h1);
    bus_wr(A_MASK, 32'h0);
    #1 chk("R9 irq masked", {31'b0, irq}, 32'h0);

    // R10 alignment mode
    set_cfg(0, 0, 0, 0, 1, 7, 0, 1);
    xfer(32'hC300_0000, 32'hC3, 32'h5A, 32'h005A_0000, "R10 msb 8-bit", 0);
    set_cfg(0, 0, 0, 0, 1, 15, 0, 1);
    xfer(32'hBEEF_0000, 32'hBEEF, 32'h1234, 32'h1234_0000, "R10 msb 16-bit", 0);
    set_cfg(0, 0, 0, 0, 0, 7, 0, 1);
    xfer(32'h0000_00C3, 32'hC3, 32'h5A, 32'h0000_5A00, "R10 lsb 8-bit", 0);
    set_cfg(0, 0, 0, 0, 0, 15, 0, 1);
    xfer(32'h0000_C3A5, 32'hC3A5, 32'h7E81, 32'h0000_7E81, "R10 lsb 16-bit", 0);

    // R12 fields locked while enabled
    set_cfg(0, 1, 0, 0, 1, 7, 0, 0);
    bus_wr(A_MODE, mk(1, 0, 1, 1, 0, 3, 5, 1) | EN);
    bus_rd(A_MODE, r); chk("R12 fields kept", r, g_cfg | EN);

    // R11 abort
    set_cfg(0, 1, 0, 1, 1, 7, 0, 0);
    bus_wr(A_TX, 32'hF0);
    repeat (40) @(negedge clk);
    bus_wr(A_MODE, g_cfg & ~EN);
    @(posedge clk);
    #1 chk("R11 sck idle after abort", {31'b0, sck}, 32'h1);
    repeat (300) @(negedge clk);
    chk("R11 sck stays idle", {31'b0, sck}, 32'h1);
    bus_rd(A_EV, r); chk("R11 no rne after abort", r, 32'h100);
    bus_rd(A_RX, r); chk("R11 rx unchanged", r, 32'h0000_7E81);

    // R13 held start
    set_cfg(0, 0, 1, 0, 1, 7, 1, 0);
    bus_wr(A_MODE, g_cfg & ~EN);
    bus_wr(A_TX, 32'h96);
    bus_rd(A_EV, r); chk("R13 tnf cleared while disabled", r, 32'h0);
    repeat (20) @(negedge clk);
    chk("R13 no sck while disabled", {31'b0, sck}, 32'h0);
    m_tx = 32'h96; m_slv = 32'h3D;
    bus_wr(A_MODE, g_cfg | EN);
    m_j = -1; m_act = 1;
    wait (m_act == 0);
    bus_rd(A_RX, r); chk("R13 rx after held start", r, 32'h3D);
    bus_rd(A_EV, r); chk("R13 events after held start", r, 32'h300);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule